// File: doc/BRIEF.md
# Six-Lane Bit-Error Checker

This block checks six 10-bit receive lanes for bit errors without a test access port. Each lane carries one parallel word per clock. An activate input starts checking. It only takes effect once it has held a new level for four clock edges in a row. A 3-bit lane-select code picks which lanes are tested. Inside each tested lane, a local pseudo-random reference is built. It is seeded from the first word that arrives after the lane enters test, and each later word is compared against it.

While a lane is under test, three things change at its outputs. Its lock output is forced low. Its data output no longer carries received words and shows an error report instead. The report form is chosen by a live report-mode input:
- **Gross mode:** a sticky all-ones flag.
- **Bit mode:** a per-bit error vector, one cycle after each word.

Lanes that are not selected pass their data and lock lines through unchanged.

A 12-bit status word gives a complete flag and a pass flag for each lane. Complete is set when a programmable number of words has been compared. Pass means the number of errored words stayed below a programmable limit.

Top module: `bist_err_checker`

## Requirements
- R1: The activate input takes effect only after it has held a new level on 4 consecutive rising clock edges. A lane's test outputs appear on the edge after that. So the lock and data outputs switch on the 5th edge after the input changes, and a pulse of 3 cycles has no effect.
- R2: Once activation has been filtered, select code k (0 to 5) tests lane k only. Code 6 tests all lanes. Code 7 tests none. While the filtered activate is low, no lane is tested.
- R3: A lane under test drives its lock output (`lock_n_o`, active low) to 0 for the whole time it is in test.
- R4: Gross mode is `bit_rpt_i`=0. In this mode a tested lane shows all 10 data bits high from the cycle after its first errored word. The flag stays high until the lane leaves test. The flag is tracked in either mode, so switching to gross mode shows any earlier error at once.
- R5: Bit mode is `bit_rpt_i`=1. In this mode a tested lane's data bit i is high exactly when bit i of the previous word was wrong. These flags are not sticky.
- R6: Status bit 2k+1 is lane k's complete flag and bit 2k is its pass flag, for k = 0..5. Lane 5 therefore occupies the two MSBs.
- R7: A lane not under test passes `rx_data_i` and `rx_lock_n_i` for that lane to its outputs unchanged, combinationally.
- R8: On the first cycle in test, the lane captures the received word as a seed. The reference history is 15 bits wide: the word fills the low 10 bits (bit 0 newest) and the upper bits are zero. Each later expected word is the history advanced 10 steps. Each step appends the XOR of history bits 14 and 13 as the new bit 0, and the word is the low 10 bits. The history never takes on received errors.
- R9: After `win_words_i` words have been compared (the seed word is not one of them), the lane sets complete. It also sets pass if fewer than `err_limit_i` words had any bit error. Both flags are kept after the lane leaves test and are cleared on its next entry.
- R10: After reset, all status bits are 0 and every lane is passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_act_i | input | 1 | Test activate, filtered over 4 edges |
| chan_sel_i | input | 3 | Lane select code (0-5 one lane, 6 all, 7 none) |
| bit_rpt_i | input | 1 | Report mode: 0 gross sticky, 1 per-bit |
| win_words_i | input | 16 | Number of words compared per test window |
| err_limit_i | input | 16 | Errored-word count at which the lane fails |
| rx_data_i | input | 60 | Received words, lane k at bits 10k+9..10k |
| rx_lock_n_i | input | 6 | Received active-low lock per lane |
| dout_o | output | 60 | Per-lane data or error report |
| lock_n_o | output | 6 | Per-lane active-low lock, forced low in test |
| bist_status_o | output | 12 | Complete/pass pair per lane |

## Verification
A wrong activate filter count shows up on the lock outputs. It moves the forced-low edge one cycle early or late, or lets a 3-cycle pulse through, so it is seen within five cycles of the input change. A reference history that falls out of step turns every compared word into an error. The report goes to all ones, or shows nonzero bit flags, one cycle after the first affected word. A miscounting window counter shows up as complete rising one edge away from the exact expected cycle. A wrong error tally shows as a wrong pass bit in a status word whose every bit is predicted.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

    localparam int WW       = 10;
    localparam int PRBS_LEN = 15;
    localparam int SEL_W    = 3;

    localparam logic [SEL_W-1:0] SEL_ALL  = 3'd6;
    localparam logic [SEL_W-1:0] SEL_NONE = 3'd7;

    typedef logic [WW-1:0]       word_t;
    typedef logic [PRBS_LEN-1:0] prbs_t;

    typedef enum logic {
        RPT_GROSS = 1'b0,
        RPT_BITS  = 1'b1
    } rpt_mode_e;

    typedef struct packed {
        logic done;
        logic pass;
    } lane_stat_t;

    // Advance the reference history by one word (WW serial steps).
    function automatic prbs_t prbs_adv(prbs_t h);
        prbs_t s;
        s = h;
        for (int i = 0; i < WW; i++) begin
            s = {s[PRBS_LEN-2:0], s[PRBS_LEN-1] ^ s[PRBS_LEN-2]};
        end
        return s;
    endfunction

endpackage

// File: rtl/bist_act_filter.sv
module bist_act_filter #(
    parameter int DB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic act_in,
    output logic act_q
);
    localparam int CW = $clog2(DB_CYC + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            run_cnt <= '0;
        end else if (act_in == act_q) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(DB_CYC - 1)) begin
            act_q   <= act_in;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bist_lane.sv
module bist_lane
    import bist_chk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_me,
    input  word_t            rx_word,
    input  rpt_mode_e        rpt_mode,
    input  logic [CNT_W-1:0] win_words,
    input  logic [CNT_W-1:0] err_limit,
    output word_t            out_word,
    output logic             on_q,
    output lane_stat_t       stat
);
    prbs_t            hist;
    prbs_t            hist_nx;
    word_t            exp_w;
    word_t            err_v;
    word_t            flags;
    logic             sticky;
    logic             any_err;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] errs;
    logic [CNT_W-1:0] errs_nx;

    always_comb begin
        hist_nx = prbs_adv(hist);
        exp_w   = hist_nx[WW-1:0];
        err_v   = rx_word ^ exp_w;
        any_err = |err_v;
        cnt_nx  = cnt + 1'b1;
        errs_nx = errs + CNT_W'(any_err);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            hist   <= '0;
            flags  <= '0;
            sticky <= 1'b0;
            cnt    <= '0;
            errs   <= '0;
            stat   <= '0;
        end else begin
            on_q <= sel_me;
            if (sel_me && !on_q) begin
                hist   <= prbs_t'(rx_word);
                flags  <= '0;
                sticky <= 1'b0;
                cnt    <= '0;
                errs   <= '0;
                stat   <= '0;
            end else if (sel_me) begin
                hist   <= hist_nx;
                flags  <= err_v;
                sticky <= sticky | any_err;
                if (!stat.done) begin
                    cnt  <= cnt_nx;
                    errs <= errs_nx;
                    if (cnt_nx == win_words) begin
                        stat.done <= 1'b1;
                        stat.pass <= (errs_nx < err_limit);
                    end
                end
            end
        end
    end

    always_comb begin
        if (!on_q)
            out_word = rx_word;
        else if (rpt_mode == RPT_BITS)
            out_word = flags;
        else
            out_word = {WW{sticky}};
    end
endmodule

// File: rtl/bist_err_checker.sv
module bist_err_checker
    import bist_chk_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int CNT_W  = 16,
    parameter int DB_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bist_act_i,
    input  logic [SEL_W-1:0]     chan_sel_i,
    input  logic                 bit_rpt_i,
    input  logic [CNT_W-1:0]     win_words_i,
    input  logic [CNT_W-1:0]     err_limit_i,
    input  logic [NCH*WW-1:0]    rx_data_i,
    input  logic [NCH-1:0]       rx_lock_n_i,
    output logic [NCH*WW-1:0]    dout_o,
    output logic [NCH-1:0]       lock_n_o,
    output logic [2*NCH-1:0]     bist_status_o
);
    logic          act_q;
    logic [NCH-1:0] lane_on;
    rpt_mode_e     rpt_mode;

    assign rpt_mode = rpt_mode_e'(bit_rpt_i);

    bist_act_filter #(.DB_CYC(DB_CYC)) u_act (
        .clk    (clk),
        .rst    (rst),
        .act_in (bist_act_i),
        .act_q  (act_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic       sel_me;
        lane_stat_t st;

        assign sel_me = act_q &&
                        ((chan_sel_i == SEL_W'(c)) || (chan_sel_i == SEL_ALL));

        bist_lane #(.CNT_W(CNT_W)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .sel_me    (sel_me),
            .rx_word   (rx_data_i[c*WW +: WW]),
            .rpt_mode  (rpt_mode),
            .win_words (win_words_i),
            .err_limit (err_limit_i),
            .out_word  (dout_o[c*WW +: WW]),
            .on_q      (lane_on[c]),
            .stat      (st)
        );

        assign lock_n_o[c]          = lane_on[c] ? 1'b0 : rx_lock_n_i[c];
        assign bist_status_o[2*c+1] = st.done;
        assign bist_status_o[2*c]   = st.pass;
    end
endmodule

// File: rtl/bist_err_checker_sva.sv
module bist_err_checker_sva
    import bist_chk_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int CNT_W  = 16,
    parameter int DB_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bist_act_i,
    input logic [SEL_W-1:0]  chan_sel_i,
    input logic              bit_rpt_i,
    input logic [NCH*WW-1:0] rx_data_i,
    input logic [NCH-1:0]    rx_lock_n_i,
    input logic [NCH*WW-1:0] dout_o,
    input logic [NCH-1:0]    lock_n_o,
    input logic [2*NCH-1:0]  bist_status_o,
    input logic              act_q,
    input logic [NCH-1:0]    lane_on
);
    if (DB_CYC == 4) begin : g_db
        assert_act_rise_R1: assert property (@(posedge clk) disable iff (rst)
            $rose(act_q) |-> ($past(bist_act_i, 1) && $past(bist_act_i, 2) &&
                              $past(bist_act_i, 3) && $past(bist_act_i, 4)));
        assert_act_fall_R1: assert property (@(posedge clk) disable iff (rst)
            $fell(act_q) |-> (!$past(bist_act_i, 1) && !$past(bist_act_i, 2) &&
                              !$past(bist_act_i, 3) && !$past(bist_act_i, 4)));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_sel_on_R2: assert property (@(posedge clk) disable iff (rst)
            (act_q && ((chan_sel_i == SEL_W'(c)) || (chan_sel_i == SEL_ALL)))
            |=> lane_on[c]);
        assert_sel_off_R2: assert property (@(posedge clk) disable iff (rst)
            (!act_q || (chan_sel_i == SEL_NONE)) |=> !lane_on[c]);
        assert_lock_low_R3: assert property (@(posedge clk) disable iff (rst)
            lane_on[c] |-> (lock_n_o[c] == 1'b0));
        assert_gross_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (lane_on[c] && $past(lane_on[c]) && !bit_rpt_i && !$past(bit_rpt_i) &&
             ($past(dout_o[c*WW +: WW]) == {WW{1'b1}}))
            |-> (dout_o[c*WW +: WW] == {WW{1'b1}}));
        assert_pass_done_R6: assert property (@(posedge clk) disable iff (rst)
            bist_status_o[2*c] |-> bist_status_o[2*c+1]);
        assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
            !lane_on[c] |-> ((dout_o[c*WW +: WW] == rx_data_i[c*WW +: WW]) &&
                             (lock_n_o[c] == rx_lock_n_i[c])));
        assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (lane_on[c] && $past(lane_on[c]) && $past(bist_status_o[2*c+1]))
            |-> bist_status_o[2*c+1]);
    end
endmodule

bind bist_err_checker bist_err_checker_sva #(
    .NCH(NCH), .CNT_W(CNT_W), .DB_CYC(DB_CYC)
) u_sva (
    .clk           (clk),
    .rst           (rst),
    .bist_act_i    (bist_act_i),
    .chan_sel_i    (chan_sel_i),
    .bit_rpt_i     (bit_rpt_i),
    .rx_data_i     (rx_data_i),
    .rx_lock_n_i   (rx_lock_n_i),
    .dout_o        (dout_o),
    .lock_n_o      (lock_n_o),
    .bist_status_o (bist_status_o),
    .act_q         (act_q),
    .lane_on       (lane_on)
);

// File: tb/tb_bist_err_checker.sv
module tb_bist_err_checker;
    logic        clk = 1'b0;
    logic        rst;
    logic        bist_act_i;
    logic [2:0]  chan_sel_i;
    logic        bit_rpt_i;
    logic [15:0] win_words_i;
    logic [15:0] err_limit_i;
    logic [59:0] rx_data_i;
    logic [5:0]  rx_lock_n_i;
    logic [59:0] dout_o;
    logic [5:0]  lock_n_o;
    logic [11:0] bist_status_o;

    always #5 clk = ~clk;

    bist_err_checker dut (
        .clk(clk), .rst(rst), .bist_act_i(bist_act_i), .chan_sel_i(chan_sel_i),
        .bit_rpt_i(bit_rpt_i), .win_words_i(win_words_i), .err_limit_i(err_limit_i),
        .rx_data_i(rx_data_i), .rx_lock_n_i(rx_lock_n_i), .dout_o(dout_o),
        .lock_n_o(lock_n_o), .bist_status_o(bist_status_o)
    );

    typedef struct {
        logic [59:0] d;
        logic [5:0]  l;
        logic [11:0] s;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    // bench-side stimulus state
    logic        v_rst, v_act, v_mode;
    logic [2:0]  v_sel;
    logic [15:0] v_win, v_lim;
    logic [9:0]  rxw [6];
    logic [14:0] h   [6];
    logic [5:0]  lk;
    logic [5:0]  bmask;
    logic [9:0]  rep [6];
    logic [11:0] st_exp;
    int          kk = 0;

    task automatic step();
        @(posedge clk);
        #2;
        rst         = v_rst;
        bist_act_i  = v_act;
        chan_sel_i  = v_sel;
        bit_rpt_i   = v_mode;
        win_words_i = v_win;
        err_limit_i = v_lim;
        rx_lock_n_i = lk;
        for (int c = 0; c < 6; c++) rx_data_i[c*10 +: 10] = rxw[c];
    endtask

    task automatic live();
        kk++;
        for (int c = 0; c < 6; c++) rxw[c] = 10'(c * 97 + kk * 13 + 5);
    endtask

    // reference stream: x^15 + x^14 + 1, bit by bit
    task automatic gen_word(input int c, output logic [9:0] w);
        for (int i = 0; i < 10; i++) h[c] = {h[c][13:0], h[c][14] ^ h[c][13]};
        w = h[c][9:0];
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        for (int c = 0; c < 6; c++) begin
            e.d[c*10 +: 10] = bmask[c] ? rep[c] : rxw[c];
            e.l[c]          = bmask[c] ? 1'b0 : lk[c];
        end
        e.s   = st_exp;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks += 3;
                if (dout_o !== e.d) begin
                    n_fail++;
                    $display("FAIL %s data got=%h exp=%h", e.tag, dout_o, e.d);
                end
                if (lock_n_o !== e.l) begin
                    n_fail++;
                    $display("FAIL %s lock got=%b exp=%b", e.tag, lock_n_o, e.l);
                end
                if (bist_status_o !== e.s) begin
                    n_fail++;
                    $display("FAIL %s status got=%h exp=%h", e.tag, bist_status_o, e.s);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] w;
        logic [9:0] seeds [6];
        v_rst = 1; v_act = 0; v_mode = 0; v_sel = 3'd7; v_win = 16'd20; v_lim = 16'd2;
        lk = 6'b101101; bmask = '0; st_exp = '0;
        for (int c = 0; c < 6; c++) begin rep[c] = '0; h[c] = '0; end
        live();
        rst = 1; bist_act_i = 0; chan_sel_i = 0; bit_rpt_i = 0; win_words_i = 0;
        err_limit_i = 0; rx_data_i = '0; rx_lock_n_i = '0;
        repeat (3) step();
        v_rst = 0;
        live(); step(); expect_now("R10 reset state");
        live(); step(); expect_now("R7 idle passthrough");

        // short pulse: 3 cycles high must not activate
        v_sel = 3'd3;
        for (int i = 0; i < 8; i++) begin
            live();
            v_act = (i < 3);
            step();
            expect_now("R1 short pulse ignored");
        end

        // scenario A: lane 2, gross mode
        v_sel = 3'd2; v_mode = 0; v_win = 16'd20; v_lim = 16'd2;
        h[2] = {5'b0, 10'h1B5};
        for (int i = 0; i < 5; i++) begin
            live(); rxw[2] = 10'h1B5; v_act = 1;
            step();
            if (i >= 3) expect_now("R1 not yet active");
        end
        for (int j = 0; j < 25; j++) begin
            live(); gen_word(2, w);
            if (j == 21) w = w ^ 10'h001;
            rxw[2] = w;
            step();
            bmask  = 6'b000100;
            rep[2] = (j >= 22) ? 10'h3FF : 10'h000;
            st_exp = (j >= 20) ? 12'h030 : 12'h000;
            if (j == 0)  expect_now("R3 lock forced on 5th edge");
            if (j == 10) expect_now("R8 prbs match R7 others live");
            if (j == 19) expect_now("R9 not complete early");
            if (j == 20) expect_now("R9 complete and pass");
            if (j == 21) expect_now("R4 no flag before error");
            if (j == 22) expect_now("R4 gross flag set");
            if (j == 24) expect_now("R4 gross flag sticky");
        end
        for (int i = 0; i < 6; i++) begin
            live(); gen_word(2, w); rxw[2] = w; v_act = 0;
            step();
            bmask = (i <= 4) ? 6'b000100 : 6'b000000;
            if (i == 4) expect_now("R1 still in test");
            if (i == 5) expect_now("R9 status kept after exit");
        end

        // scenario B: all lanes, bit mode
        v_sel = 3'd6; v_mode = 1; v_win = 16'd30; v_lim = 16'd2;
        for (int c = 0; c < 6; c++) begin
            seeds[c] = 10'h155 + 10'(c * 3);
            h[c]     = {5'b0, seeds[c]};
        end
        for (int i = 0; i < 5; i++) begin
            live();
            for (int c = 0; c < 6; c++) rxw[c] = seeds[c];
            v_act = 1;
            step();
            if (i == 4) expect_now("R2 entry pending");
        end
        for (int j = 0; j < 32; j++) begin
            live();
            for (int c = 0; c < 6; c++) begin
                gen_word(c, w);
                if (c == 0 && j == 2) w = w ^ 10'h008;
                if (c == 1 && j == 3) w = w ^ 10'h200;
                if (c == 1 && j == 4) w = w ^ 10'h001;
                if (c == 1 && j == 5) w = w ^ 10'h030;
                rxw[c] = w;
            end
            if (j == 31) v_mode = 0;
            step();
            bmask = 6'b111111;
            for (int c = 0; c < 6; c++) rep[c] = '0;
            if (j == 3) rep[0] = 10'h008;
            if (j == 4) rep[1] = 10'h200;
            if (j == 5) rep[1] = 10'h001;
            if (j == 6) rep[1] = 10'h030;
            if (j == 31) begin rep[0] = 10'h3FF; rep[1] = 10'h3FF; end
            st_exp = (j >= 30) ? 12'hFFB : 12'h000;
            if (j == 0)  expect_now("R2 all lanes R9 status cleared");
            if (j == 3)  expect_now("R5 bit flag lane0");
            if (j == 4)  expect_now("R5 not sticky lane1 bit9");
            if (j == 5)  expect_now("R5 lane1 bit0");
            if (j == 6)  expect_now("R5 lane1 bits 5:4");
            if (j == 7)  expect_now("R5 flags clear");
            if (j == 29) expect_now("R9 window open");
            if (j == 30) expect_now("R6 status layout R9 pass fail");
            if (j == 31) expect_now("R4 sticky across mode switch");
        end
        for (int i = 0; i < 6; i++) begin
            live();
            for (int c = 0; c < 6; c++) begin gen_word(c, w); rxw[c] = w; end
            v_act = 0;
            step();
            bmask = (i <= 4) ? 6'b111111 : 6'b000000;
            if (i == 5) expect_now("R7 all lanes released");
        end

        // scenario C: idle code with activate high
        v_sel = 3'd7;
        for (int i = 0; i < 7; i++) begin
            live(); v_act = 1;
            step();
            if (i >= 5) expect_now("R2 idle code");
        end
        for (int i = 0; i < 6; i++) begin
            live(); v_act = 0;
            step();
        end
        expect_now("R7 final passthrough");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule